// File: doc/BRIEF.md
# Bus-Matching Port Width Adapter

This block connects a 36-bit internal FIFO data path to an external port whose width is set once, at master reset, to a long word (36 bits), a half word (18 bits) or a byte (9 bits). A single port both drains one FIFO and fills another. The adapter therefore works in two directions.

In the read direction it splits each 36-bit word taken from the head of a FIFO into one, two or four beats. In the write direction it gathers one, two or four beats into a 36-bit word and commits that word to the other FIFO. An endianness setting decides whether the most or the least significant slice travels first. The setting applies to both directions.

A master reset captures the width and endianness settings and clears all sequencing. A partial reset clears only the sequencing and any partly gathered word, so the captured settings stay in force. The FIFO side follows a valid/ready word handshake. The port side carries an enable and data, with narrow data on the low bits of the 36-bit port buses.

Top module: `bus_width_adapter`

## Requirements
- R1: The width code (`cfg_size`) and endianness (`cfg_big`) are captured on every clock edge at which `rst` is high. Changes to them while `rst` is low have no effect on any output.
- R2: With width code 0 (long word), the read side is a same-cycle pass-through. `port_rd_data` equals `fifo_rd_word`, and `fifo_rd_ready` equals `port_rd_en & fifo_rd_valid`.
- R3: With width code 1 (half word), each word leaves as two 18-bit beats on `port_rd_data[17:0]`, with bits 35:18 zero. In big-endian mode (`cfg_big`=1) bits 35:18 of the word come first; in little-endian mode bits 17:0 come first.
- R4: With width code 2 (byte), each word leaves as four 9-bit beats on `port_rd_data[8:0]`, with bits 35:9 zero. In big-endian mode the order is bits 35:27, 26:18, 17:9, 8:0; little-endian mode uses the reverse order.
- R5: A read beat is accepted only when `port_rd_en` and `fifo_rd_valid` are both high. `fifo_rd_ready` pulses only with the acceptance of the last beat of a word. An enable without valid data, or valid data without an enable, leaves the beat position unchanged.
- R6: With width code 0, the write side is a same-cycle pass-through. `fifo_wr_valid` equals `port_wr_en`, `fifo_wr_word` equals `port_wr_data`, and `port_wr_ready` equals `fifo_wr_ready`.
- R7: With width code 1 or 2, write beats fill the word in the same slice order as R3/R4. Only the low 18 or 9 bits of `port_wr_data` are used. `fifo_wr_valid` is high only during the final beat, and `fifo_wr_word` then carries the complete word.
- R8: A final write beat is held, with `port_wr_ready` low, while `fifo_wr_ready` is low. Non-final beats are always accepted, with `port_wr_ready` high.
- R9: `prst` returns both directions to the first beat and discards a partly gathered word, while keeping the captured width and endianness.
- R10: Width code 3 is captured as long-word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high; captures configuration |
| prst | input | 1 | Partial reset, synchronous, active high; clears sequencing only |
| cfg_size | input | 2 | Port width code: 0 long, 1 half word, 2 byte, 3 long |
| cfg_big | input | 1 | 1 = most significant slice first |
| fifo_rd_word | input | 36 | Head word of the FIFO being drained |
| fifo_rd_valid | input | 1 | Head word is valid |
| fifo_rd_ready | output | 1 | Pop the head word |
| port_rd_en | input | 1 | Port takes a read beat |
| port_rd_avail | output | 1 | A read beat is available |
| port_rd_data | output | 36 | Read beat, narrow data on the low bits |
| port_wr_en | input | 1 | Port offers a write beat |
| port_wr_data | input | 36 | Write beat, narrow data on the low bits |
| port_wr_ready | output | 1 | Write beat is accepted this cycle |
| fifo_wr_word | output | 36 | Assembled word for the FIFO being filled |
| fifo_wr_valid | output | 1 | Push the assembled word |
| fifo_wr_ready | input | 1 | Target FIFO can take a word |

## Verification
All four width codes are swept against both endianness values. Each run uses distinct word patterns whose slices all differ, so a swapped, shifted or repeated slice shows up as a wrong value. Read runs insert idle cycles with the enable low and with valid low, which separates correct beat advancement from advancement on any single condition. Write runs put junk above the narrow lane and stall the final beat, which catches the use of upper bits and any push or acceptance under back-pressure. A partial reset issued mid-word, followed by full words, shows that the leftover beat position and the gathered slices are dropped while the captured settings stay.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'd0,
    SZ_HALF = 2'd1,
    SZ_QUAR = 2'd2
  } size_e;

  function automatic logic [2:0] beats_of(size_e s);
    case (s)
      SZ_HALF: return 3'd2;
      SZ_QUAR: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // slice slot carried by beat position idx, given beat count and order
  function automatic logic [1:0] slot_of(logic [1:0] idx, logic [2:0] n, logic big);
    logic [2:0] rev;
    rev = n - 3'd1 - {1'b0, idx};
    return big ? rev[1:0] : idx;
  endfunction

endpackage

// File: rtl/bwa_cfg.sv
module bwa_cfg
  import bwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] size_in,
  input  logic       big_in,
  output size_e      size_q,
  output logic       big_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      case (size_in)
        2'd1:    size_q <= SZ_HALF;
        2'd2:    size_q <= SZ_QUAR;
        default: size_q <= SZ_LONG;
      endcase
      big_q <= big_in;
    end
  end

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(size_q) && $stable(big_q)));

endmodule

// File: rtl/bwa_unpack.sv
module bwa_unpack
  import bwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prst,
  input  size_e             size,
  input  logic              big,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              en_i,
  output logic              avail_o,
  output logic [WORD_W-1:0] data_o
);

  localparam int HALF_W = WORD_W / 2;
  localparam int QUAR_W = WORD_W / 4;

  logic [1:0] idx;
  logic [2:0] n;
  logic [1:0] slot;
  logic       last;
  logic       take;

  assign n    = beats_of(size);
  assign last = ({1'b0, idx} == (n - 3'd1));
  assign slot = slot_of(idx, n, big);
  assign take = en_i & valid_i;

  always_ff @(posedge clk) begin
    if (rst || prst) begin
      idx <= '0;
    end else if (take) begin
      idx <= last ? 2'd0 : idx + 2'd1;
    end
  end

  always_comb begin
    data_o = '0;
    case (size)
      SZ_HALF: data_o[HALF_W-1:0] = word_i[slot[0]*HALF_W +: HALF_W];
      SZ_QUAR: data_o[QUAR_W-1:0] = word_i[slot*QUAR_W +: QUAR_W];
      default: data_o = word_i;
    endcase
  end

  assign ready_o = take & last;
  assign avail_o = valid_i;

  // R5
  pop_needs_head_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (valid_i && en_i));

  // R5
  beat_range_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, idx} < n));

  // R9
  rd_prst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    prst |=> (idx == 2'd0));

endmodule

// File: rtl/bwa_pack.sv
module bwa_pack
  import bwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prst,
  input  size_e             size,
  input  logic              big,
  input  logic              en_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ready_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  input  logic              wready_i
);

  localparam int HALF_W = WORD_W / 2;
  localparam int QUAR_W = WORD_W / 4;

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;
  logic [1:0]        idx;
  logic [2:0]        n;
  logic [1:0]        slot;
  logic              last;
  logic              take;

  assign n    = beats_of(size);
  assign last = ({1'b0, idx} == (n - 3'd1));
  assign slot = slot_of(idx, n, big);

  always_comb begin
    merged = acc;
    case (size)
      SZ_HALF: merged[slot[0]*HALF_W +: HALF_W] = data_i[HALF_W-1:0];
      SZ_QUAR: merged[slot*QUAR_W +: QUAR_W] = data_i[QUAR_W-1:0];
      default: merged = data_i;
    endcase
  end

  assign ready_o = last ? wready_i : 1'b1;
  assign take    = en_i & ready_o;
  assign valid_o = en_i & last;
  assign word_o  = merged;

  always_ff @(posedge clk) begin
    if (rst || prst) begin
      idx <= '0;
      acc <= '0;
    end else if (take) begin
      idx <= last ? 2'd0 : idx + 2'd1;
      acc <= last ? '0 : merged;
    end
  end

  // R7
  push_on_beat_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> en_i);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst || prst)
    (valid_o && !wready_i) |=> $stable(idx));

  // R9
  wr_prst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    prst |=> (idx == 2'd0 && acc == '0));

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prst,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_big,
  input  logic [WORD_W-1:0] fifo_rd_word,
  input  logic              fifo_rd_valid,
  output logic              fifo_rd_ready,
  input  logic              port_rd_en,
  output logic              port_rd_avail,
  output logic [WORD_W-1:0] port_rd_data,
  input  logic              port_wr_en,
  input  logic [WORD_W-1:0] port_wr_data,
  output logic              port_wr_ready,
  output logic [WORD_W-1:0] fifo_wr_word,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready
);

  size_e size_q;
  logic  big_q;

  bwa_cfg cfg_i (
    .clk     (clk),
    .rst     (rst),
    .size_in (cfg_size),
    .big_in  (cfg_big),
    .size_q  (size_q),
    .big_q   (big_q)
  );

  bwa_unpack #(.WORD_W(WORD_W)) unpack_i (
    .clk     (clk),
    .rst     (rst),
    .prst    (prst),
    .size    (size_q),
    .big     (big_q),
    .word_i  (fifo_rd_word),
    .valid_i (fifo_rd_valid),
    .ready_o (fifo_rd_ready),
    .en_i    (port_rd_en),
    .avail_o (port_rd_avail),
    .data_o  (port_rd_data)
  );

  bwa_pack #(.WORD_W(WORD_W)) pack_i (
    .clk      (clk),
    .rst      (rst),
    .prst     (prst),
    .size     (size_q),
    .big      (big_q),
    .en_i     (port_wr_en),
    .data_i   (port_wr_data),
    .ready_o  (port_wr_ready),
    .word_o   (fifo_wr_word),
    .valid_o  (fifo_wr_valid),
    .wready_i (fifo_wr_ready)
  );

  // R6
  wr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (size_q == SZ_LONG) |-> (fifo_wr_valid == port_wr_en && fifo_wr_word == port_wr_data));

endmodule

// File: tb/bus_width_adapter_tb.sv
module bus_width_adapter_tb_top;

  logic        clk = 1'b0;
  logic        rst, prst;
  logic [1:0]  cfg_size;
  logic        cfg_big;
  logic [35:0] fifo_rd_word;
  logic        fifo_rd_valid, fifo_rd_ready;
  logic        port_rd_en, port_rd_avail;
  logic [35:0] port_rd_data;
  logic        port_wr_en;
  logic [35:0] port_wr_data;
  logic        port_wr_ready;
  logic [35:0] fifo_wr_word;
  logic        fifo_wr_valid, fifo_wr_ready;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_width_adapter dut_i (
    .clk(clk), .rst(rst), .prst(prst), .cfg_size(cfg_size), .cfg_big(cfg_big),
    .fifo_rd_word(fifo_rd_word), .fifo_rd_valid(fifo_rd_valid), .fifo_rd_ready(fifo_rd_ready),
    .port_rd_en(port_rd_en), .port_rd_avail(port_rd_avail), .port_rd_data(port_rd_data),
    .port_wr_en(port_wr_en), .port_wr_data(port_wr_data), .port_wr_ready(port_wr_ready),
    .fifo_wr_word(fifo_wr_word), .fifo_wr_valid(fifo_wr_valid), .fifo_wr_ready(fifo_wr_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int beats(int s);
    return (s == 1) ? 2 : (s == 2) ? 4 : 1;
  endfunction

  function automatic logic [35:0] slice_exp(logic [35:0] w, int n, int k, bit big);
    int wd;
    int slot;
    logic [35:0] m;
    wd = 36 / n;
    slot = big ? (n - 1 - k) : k;
    m = (wd == 36) ? '1 : ((36'd1 << wd) - 36'd1);
    return (w >> (slot * wd)) & m;
  endfunction

  function automatic logic [35:0] pattern(int s, int b, int w);
    return 36'h9_1A2B_3C4D ^ (36'h1_0F1E_2D3C * 36'(w + 1)) ^ (36'h0_5060_7080 * 36'(s * 2 + b));
  endfunction

  function automatic logic [35:0] junked(logic [35:0] v, int n);
    int wd;
    wd = 36 / n;
    return (n == 1) ? v : (v | (36'hA_5A5A_5A5A << wd));
  endfunction

  task automatic run_cfg(input int s, input int b);
    int n;
    string rtag, wtag;
    logic [35:0] w, e;
    n = beats(s);
    rtag = (s == 3) ? "R10" : (n == 1) ? "R2" : (n == 2) ? "R3" : "R4";
    wtag = (s == 3) ? "R10" : (n == 1) ? "R6" : "R7";

    @(negedge clk);
    rst = 1; prst = 0; cfg_size = 2'(s); cfg_big = b[0];
    port_rd_en = 0; fifo_rd_valid = 0; port_wr_en = 0; fifo_wr_ready = 1;
    @(negedge clk);
    rst = 0;
    // R1: settings changed after reset must not matter
    cfg_size = 2'((s + 1) % 4); cfg_big = ~b[0];
    #1;
    chk(!fifo_rd_ready && !fifo_wr_valid, "R1 reset idle", {34'd0, fifo_rd_ready, fifo_wr_valid}, 36'd0);

    // read direction
    for (int wi = 0; wi < 3; wi++) begin
      w = pattern(s, b, wi);
      for (int k = 0; k < n; k++) begin
        if (k == 0 && wi == 1) begin
          @(negedge clk); fifo_rd_word = w; fifo_rd_valid = 1; port_rd_en = 0; #1;
          chk(!fifo_rd_ready && port_rd_avail, "R5 no enable", {35'd0, fifo_rd_ready}, 36'd0);
        end
        if (k == 0 && wi == 2) begin
          @(negedge clk); fifo_rd_valid = 0; port_rd_en = 1; #1;
          chk(!fifo_rd_ready && !port_rd_avail, "R5 no valid", {35'd0, fifo_rd_ready}, 36'd0);
        end
        @(negedge clk); fifo_rd_word = w; fifo_rd_valid = 1; port_rd_en = 1; #1;
        e = slice_exp(w, n, k, b[0]);
        chk(port_rd_data == e, rtag, port_rd_data, e);
        chk(fifo_rd_ready == (k == n - 1), "R5 pop", {35'd0, fifo_rd_ready}, {35'd0, k == n - 1});
      end
    end
    @(negedge clk); port_rd_en = 0; fifo_rd_valid = 0;

    // write direction
    for (int wi = 0; wi < 3; wi++) begin
      w = pattern(s, b, wi + 5);
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        port_wr_en = 1; port_wr_data = junked(slice_exp(w, n, k, b[0]), n);
        if (wi == 1 && k == n - 1) begin
          fifo_wr_ready = 0; #1;
          chk(!port_wr_ready && fifo_wr_valid, "R8 final stall", {35'd0, port_wr_ready}, 36'd0);
          @(negedge clk);
        end
        fifo_wr_ready = (wi == 2 && k != n - 1) ? 1'b0 : 1'b1;
        #1;
        chk(port_wr_ready, "R8 accept", {35'd0, port_wr_ready}, 36'd1);
        chk(fifo_wr_valid == (k == n - 1), "R7 push", {35'd0, fifo_wr_valid}, {35'd0, k == n - 1});
        if (k == n - 1) chk(fifo_wr_word == w, wtag, fifo_wr_word, w);
      end
    end
    @(negedge clk); port_wr_en = 0; fifo_wr_ready = 1;

    // partial reset mid-word
    if (n > 1) begin
      @(negedge clk);
      fifo_rd_word = 36'h3_C3C3_C3C3; fifo_rd_valid = 1; port_rd_en = 1;
      port_wr_en = 1; port_wr_data = 36'hF_FFFF_FFFF;
      @(negedge clk);
      port_rd_en = 0; port_wr_en = 0; prst = 1;
      @(negedge clk);
      prst = 0;
      w = pattern(s, b, 9);
      for (int k = 0; k < n; k++) begin
        @(negedge clk); fifo_rd_word = w; fifo_rd_valid = 1; port_rd_en = 1; #1;
        e = slice_exp(w, n, k, b[0]);
        chk(port_rd_data == e, "R9 read restart", port_rd_data, e);
      end
      @(negedge clk); port_rd_en = 0; fifo_rd_valid = 0;
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        port_wr_en = 1; port_wr_data = junked(slice_exp(w, n, k, b[0]), n); #1;
        if (k == n - 1) chk(fifo_wr_valid && fifo_wr_word == w, "R9 write restart", fifo_wr_word, w);
      end
      @(negedge clk); port_wr_en = 0;
    end
  endtask

  initial begin
    rst = 1; prst = 0; cfg_size = 0; cfg_big = 0;
    fifo_rd_word = '0; fifo_rd_valid = 0; port_rd_en = 0;
    port_wr_en = 0; port_wr_data = '0; fifo_wr_ready = 1;
    repeat (2) @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 2; b++)
        run_cfg(s, b);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule